// File: doc/BRIEF.md
# Parallel Nonvolatile Programming Port

This block is the device-side controller for a parallel programming and verify mode of an on-chip nonvolatile store. An external programmer holds the device in reset and performs a fixed entry handshake on a strobe-enable line. Inside the resulting session, an 8-bit mode code picks a storage region. The programmer then writes bytes into that region with low pulses on a program strobe, or reads them back on the data port.

There are five regions, all modelled as register arrays: code memory, two configuration bytes, three lock bits, a 128-byte encryption array and a read-only signature. Each region answers only inside its own address window. A write can only clear bits, so the stores behave like one-time-programmable cells. Programming voltage is reduced to a digital enable input. The data port is split into an input, an output and an output enable.

Top module: `nvp_port`

## Requirements
- R1: A synchronous high `rst` sets every stored bit to 1 and leaves `data_oe` low.
- R2: A session opens only under a strict order. First, `dev_hold`=1, `strobe_n`=1, `pulse_n`=1 and `mode_code`=FFh hold for at least ARM_CYC (default 2) consecutive clock edges. Then `strobe_n` falls while `dev_hold` stays 1. A fall after fewer idle edges opens nothing.
- R3: A session closes when `dev_hold` drops or `strobe_n` rises. `data_oe` falls at once. A new session needs the full entry sequence again.
- R4: Mode 68h addresses code memory at 0000h to 2^CODE_AW-1.
- R5: Mode 69h addresses the two configuration bytes at FFF8h and FFF9h.
- R6: Mode 6Bh addresses three lock bits at 0001h, 0002h and 0003h. A write stores data bit 0. A read returns 7Fh in bits 7:1 and the stored bit in bit 0.
- R7: Mode 6Ch addresses the encryption array at 0000h to 007Fh.
- R8: A write happens once for each falling edge of `pulse_n` seen in a session while `prog_en`=1. Holding the strobe low does not repeat the write. With `prog_en`=0, no write happens.
- R9: Each write stores the AND of the new data and the old byte, so a 0 never returns to 1.
- R10: `data_oe` is 1 only in a session with `prog_en`=0 and `pulse_n`=1. In that case `data_out` carries the addressed byte. While programming, and outside a session, `data_oe` is 0.
- R11: An unknown mode code, or an address outside the selected window, reads back FFh and changes nothing on a write.
- R12: Mode 60h reads the signature bytes 5Ah, C3h and 3Ch at 0000h, 0001h and 0002h. Writes in this mode have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| dev_hold | input | 1 | Device reset level; must stay 1 for the whole session |
| prog_en | input | 1 | Programming voltage present (1) or normal supply (0) |
| strobe_n | input | 1 | Active-low strobe-enable used for session entry |
| pulse_n | input | 1 | Active-low program strobe |
| mode_code | input | 8 | Region select code |
| addr_hi | input | 8 | Address bits 15:8 |
| addr_lo | input | 8 | Address bits 7:0 |
| data_in | input | 8 | Program data |
| data_out | output | 8 | Verify data |
| data_oe | output | 1 | Drive enable for `data_out` |

## Verification
The bench uses the defaults CODE_AW=8 and ARM_CYC=2. With a 256-byte code window, random addresses land both on the window's last byte and just past it, so wrap and alias faults show up in read-back. ARM_CYC=2 makes the minimum entry distance one edge away from a rejected attempt. This lets a single short idle phase exercise the refused-entry path.

// File: rtl/nvp_pkg.sv
package nvp_pkg;
    localparam logic [7:0] MC_CODE = 8'h68;
    localparam logic [7:0] MC_CFG  = 8'h69;
    localparam logic [7:0] MC_LOCK = 8'h6B;
    localparam logic [7:0] MC_ENC  = 8'h6C;
    localparam logic [7:0] MC_SIG  = 8'h60;
    localparam logic [7:0] MC_IDLE = 8'hFF;

    localparam int ENC_DEPTH  = 128;
    localparam int CFG_DEPTH  = 2;
    localparam int LOCK_DEPTH = 3;
    localparam int SIG_DEPTH  = 3;

    typedef enum logic [2:0] {
        RG_NONE, RG_CODE, RG_CFG, RG_LOCK, RG_ENC, RG_SIG
    } region_e;

    typedef struct packed {
        region_e     rg;
        logic [14:0] off;
    } target_t;

    typedef enum logic [1:0] {SQ_IDLE, SQ_ARM, SQ_SESS} seq_e;

    function automatic logic [7:0] sig_byte(input logic [1:0] idx);
        case (idx)
            2'd0:    return 8'h5A;
            2'd1:    return 8'hC3;
            2'd2:    return 8'h3C;
            default: return 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/nvp_seq.sv
module nvp_seq
    import nvp_pkg::*;
#(
    parameter int ARM_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic dev_hold,
    input  logic prog_en,
    input  logic strobe_n,
    input  logic pulse_n,
    input  logic idle_code,
    output logic in_sess,
    output logic wr_pulse
);
    localparam int CW = $clog2(ARM_CYC + 1);

    seq_e          state;
    logic [CW-1:0] arm_cnt;
    logic          pulse_q;
    logic          idle_ok;

    assign idle_ok  = dev_hold && strobe_n && pulse_n && idle_code;
    assign in_sess  = (state == SQ_SESS) && dev_hold && !strobe_n;
    assign wr_pulse = in_sess && prog_en && pulse_q && !pulse_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            arm_cnt <= '0;
            pulse_q <= 1'b1;
        end else begin
            pulse_q <= pulse_n;
            case (state)
                SQ_IDLE: begin
                    if (idle_ok) begin
                        state   <= SQ_ARM;
                        arm_cnt <= CW'(1);
                    end
                end
                SQ_ARM: begin
                    if (dev_hold && !strobe_n && (arm_cnt >= CW'(ARM_CYC))) begin
                        state <= SQ_SESS;
                    end else if (idle_ok) begin
                        if (arm_cnt < CW'(ARM_CYC)) arm_cnt <= arm_cnt + CW'(1);
                    end else begin
                        state   <= SQ_IDLE;
                        arm_cnt <= '0;
                    end
                end
                default: begin
                    if (!dev_hold || strobe_n) begin
                        state   <= SQ_IDLE;
                        arm_cnt <= '0;
                    end
                end
            endcase
        end
    end

    // R2
    sess_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(state == SQ_SESS) |-> ($past(arm_cnt) == CW'(ARM_CYC)));

    // R3
    sess_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_SESS && (strobe_n || !dev_hold)) |=> (state != SQ_SESS));

    // R8
    wr_once_chk: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |=> !wr_pulse);
endmodule

// File: rtl/nvp_decode.sv
module nvp_decode
    import nvp_pkg::*;
#(
    parameter int CODE_AW = 8
) (
    input  logic [7:0]  mode_code,
    input  logic [15:0] addr,
    output target_t     tgt
);
    always_comb begin
        tgt.rg  = RG_NONE;
        tgt.off = '0;
        case (mode_code)
            MC_CODE: if ((addr >> CODE_AW) == 16'd0) begin
                tgt.rg  = RG_CODE;
                tgt.off = addr[14:0];
            end
            MC_CFG: if (addr[15:1] == 15'h7FFC) begin
                tgt.rg  = RG_CFG;
                tgt.off = {14'd0, addr[0]};
            end
            MC_LOCK: if (addr >= 16'd1 && addr <= 16'(LOCK_DEPTH)) begin
                tgt.rg  = RG_LOCK;
                tgt.off = 15'(addr - 16'd1);
            end
            MC_ENC: if (addr < 16'(ENC_DEPTH)) begin
                tgt.rg  = RG_ENC;
                tgt.off = addr[14:0];
            end
            MC_SIG: if (addr < 16'(SIG_DEPTH)) begin
                tgt.rg  = RG_SIG;
                tgt.off = addr[14:0];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/nvp_store.sv
module nvp_store
    import nvp_pkg::*;
#(
    parameter int CODE_AW = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  target_t    tgt,
    input  logic [7:0] wdata,
    output logic [7:0] rdata
);
    localparam int CODE_DEPTH = 1 << CODE_AW;

    logic [7:0]            code_mem [CODE_DEPTH];
    logic [7:0]            enc_mem  [ENC_DEPTH];
    logic [7:0]            cfg_mem  [CFG_DEPTH];
    logic [LOCK_DEPTH-1:0] lock_bits;

    logic [CODE_AW-1:0] code_idx;
    logic [6:0]         enc_idx;

    assign code_idx = tgt.off[CODE_AW-1:0];
    assign enc_idx  = tgt.off[6:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CODE_DEPTH; i++) code_mem[i] <= 8'hFF;
            for (int i = 0; i < ENC_DEPTH; i++)  enc_mem[i]  <= 8'hFF;
            for (int i = 0; i < CFG_DEPTH; i++)  cfg_mem[i]  <= 8'hFF;
            lock_bits <= '1;
        end else if (wr_en) begin
            case (tgt.rg)
                RG_CODE: code_mem[code_idx]   <= code_mem[code_idx] & wdata;
                RG_ENC:  enc_mem[enc_idx]     <= enc_mem[enc_idx] & wdata;
                RG_CFG:  cfg_mem[tgt.off[0]]  <= cfg_mem[tgt.off[0]] & wdata;
                RG_LOCK: case (tgt.off[1:0])
                    2'd0:    lock_bits[0] <= lock_bits[0] & wdata[0];
                    2'd1:    lock_bits[1] <= lock_bits[1] & wdata[0];
                    default: lock_bits[2] <= lock_bits[2] & wdata[0];
                endcase
                default: ;
            endcase
        end
    end

    always_comb begin
        case (tgt.rg)
            RG_CODE: rdata = code_mem[code_idx];
            RG_ENC:  rdata = enc_mem[enc_idx];
            RG_CFG:  rdata = cfg_mem[tgt.off[0]];
            RG_LOCK: case (tgt.off[1:0])
                2'd0:    rdata = {7'h7F, lock_bits[0]};
                2'd1:    rdata = {7'h7F, lock_bits[1]};
                default: rdata = {7'h7F, lock_bits[2]};
            endcase
            RG_SIG:  rdata = sig_byte(tgt.off[1:0]);
            default: rdata = 8'hFF;
        endcase
    end

    // R9
    enc_clear_only_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && tgt.rg == RG_ENC) |=>
        ((enc_mem[$past(enc_idx)] & ~$past(enc_mem[enc_idx])) == 8'h00));
endmodule

// File: rtl/nvp_port.sv
module nvp_port
    import nvp_pkg::*;
#(
    parameter int CODE_AW = 8,
    parameter int ARM_CYC = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dev_hold,
    input  logic       prog_en,
    input  logic       strobe_n,
    input  logic       pulse_n,
    input  logic [7:0] mode_code,
    input  logic [7:0] addr_hi,
    input  logic [7:0] addr_lo,
    input  logic [7:0] data_in,
    output logic [7:0] data_out,
    output logic       data_oe
);
    logic       in_sess;
    logic       wr_pulse;
    target_t    tgt;
    logic [7:0] rd_byte;

    nvp_seq #(.ARM_CYC(ARM_CYC)) u_seq (
        .clk(clk), .rst(rst), .dev_hold(dev_hold), .prog_en(prog_en),
        .strobe_n(strobe_n), .pulse_n(pulse_n),
        .idle_code(mode_code == MC_IDLE),
        .in_sess(in_sess), .wr_pulse(wr_pulse)
    );

    nvp_decode #(.CODE_AW(CODE_AW)) u_dec (
        .mode_code(mode_code), .addr({addr_hi, addr_lo}), .tgt(tgt)
    );

    nvp_store #(.CODE_AW(CODE_AW)) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_pulse), .tgt(tgt),
        .wdata(data_in), .rdata(rd_byte)
    );

    assign data_oe  = in_sess && !prog_en && pulse_n;
    assign data_out = rd_byte;

    // R10
    oe_prog_chk: assert property (@(posedge clk) disable iff (rst)
        prog_en |-> !data_oe);

    // R11
    miss_ff_chk: assert property (@(posedge clk) disable iff (rst)
        (data_oe && tgt.rg == RG_NONE) |-> (data_out == 8'hFF));
endmodule

// File: tb/nvp_port_tb.sv
module nvp_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CODE_AW    = 8;
    localparam int CODE_N     = 1 << CODE_AW;

    logic       clk = 1'b0;
    logic       rst, dev_hold, prog_en, strobe_n, pulse_n;
    logic [7:0] mode_code, addr_hi, addr_lo, data_in, data_out;
    logic       data_oe;

    int total = 0;
    int bad   = 0;

    logic [7:0] m_code [CODE_N];
    logic [7:0] m_enc  [128];
    logic [7:0] m_cfg  [2];
    logic [2:0] m_lock;

    nvp_port #(.CODE_AW(CODE_AW), .ARM_CYC(2)) u_dut (
        .clk(clk), .rst(rst), .dev_hold(dev_hold), .prog_en(prog_en),
        .strobe_n(strobe_n), .pulse_n(pulse_n), .mode_code(mode_code),
        .addr_hi(addr_hi), .addr_lo(addr_lo), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [7:0] m, input logic [15:0] a);
        case (m)
            8'h68: return (a < CODE_N) ? m_code[a[CODE_AW-1:0]] : 8'hFF;
            8'h69: return (a == 16'hFFF8 || a == 16'hFFF9) ? m_cfg[a[0]] : 8'hFF;
            8'h6B: return (a >= 1 && a <= 3) ? {7'h7F, m_lock[a[1:0]-2'd1]} : 8'hFF;
            8'h6C: return (a < 128) ? m_enc[a[6:0]] : 8'hFF;
            8'h60: return (a == 0) ? 8'h5A : (a == 1) ? 8'hC3 : (a == 2) ? 8'h3C : 8'hFF;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic model_write(input logic [7:0] m, input logic [15:0] a, input logic [7:0] d);
        case (m)
            8'h68: if (a < CODE_N) m_code[a[CODE_AW-1:0]] &= d;
            8'h69: if (a == 16'hFFF8 || a == 16'hFFF9) m_cfg[a[0]] &= d;
            8'h6B: if (a >= 1 && a <= 3) m_lock[a[1:0]-2'd1] &= d[0];
            8'h6C: if (a < 128) m_enc[a[6:0]] &= d;
            default: ;
        endcase
    endtask

    task automatic open_sess(input int idle_edges);
        dev_hold = 1; strobe_n = 1; pulse_n = 1; prog_en = 0; mode_code = 8'hFF;
        repeat (idle_edges) @(posedge clk);
        #1 strobe_n = 0;
        @(posedge clk); #1;
    endtask

    task automatic close_sess();
        strobe_n = 1; mode_code = 8'h00;
        @(posedge clk); #1;
    endtask

    task automatic do_write(input logic [7:0] m, input logic [15:0] a, input logic [7:0] d);
        mode_code = m; {addr_hi, addr_lo} = a; data_in = d;
        prog_en = 1; pulse_n = 0;
        @(posedge clk); #1 pulse_n = 1;
        @(posedge clk); #1 prog_en = 0;
        model_write(m, a, d);
    endtask

    task automatic do_verify(input logic [7:0] m, input logic [15:0] a, input string req);
        logic [7:0] e;
        mode_code = m; {addr_hi, addr_lo} = a; prog_en = 0; pulse_n = 1;
        e = exp_read(m, a);
        @(negedge clk);
        check(data_oe === 1'b1, req, data_oe, 1);
        check(data_out === e, req, data_out, e);
        @(posedge clk); #1;
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [7:0]  m;
        logic [15:0] a;
        void'($urandom(32'd1234));
        for (int i = 0; i < CODE_N; i++) m_code[i] = 8'hFF;
        for (int i = 0; i < 128; i++)    m_enc[i]  = 8'hFF;
        m_cfg[0] = 8'hFF; m_cfg[1] = 8'hFF; m_lock = 3'b111;

        rst = 1; dev_hold = 0; prog_en = 0; strobe_n = 1; pulse_n = 1;
        mode_code = 8'h00; addr_hi = 0; addr_lo = 0; data_in = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        check(data_oe === 1'b0, "R1 oe after reset", data_oe, 0);
        @(posedge clk); #1;

        // R2: strobe falls after one idle edge only
        open_sess(1);
        mode_code = 8'h68; {addr_hi, addr_lo} = 16'h0000;
        @(negedge clk);
        check(data_oe === 1'b0, "R2 early entry refused", data_oe, 0);
        @(posedge clk); #1;
        close_sess();

        open_sess(2);
        // R1: storage reset to FFh
        do_verify(8'h68, 16'h0000, "R1 code reset");
        do_verify(8'h6C, 16'h007F, "R1 enc reset");
        do_verify(8'h69, 16'hFFF9, "R1 cfg reset");

        // R4 code window edges, R11 out of window
        do_write(8'h68, 16'h00FF, 8'hA5);
        do_verify(8'h68, 16'h00FF, "R4 code top");
        do_write(8'h68, 16'h0100, 8'h00);
        do_verify(8'h68, 16'h0100, "R11 code out of window");
        do_verify(8'h68, 16'h0000, "R11 no alias to 0");

        // R5
        do_write(8'h69, 16'hFFF8, 8'h3C);
        do_write(8'h69, 16'hFFF9, 8'hC0);
        do_verify(8'h69, 16'hFFF8, "R5 cfg0");
        do_verify(8'h69, 16'hFFF9, "R5 cfg1");
        do_write(8'h69, 16'hFFFA, 8'h00);
        do_verify(8'h69, 16'hFFFA, "R11 cfg miss");

        // R6
        do_write(8'h6B, 16'h0002, 8'hFE);
        do_write(8'h6B, 16'h0003, 8'h01);
        do_verify(8'h6B, 16'h0002, "R6 lock1 cleared");
        do_verify(8'h6B, 16'h0003, "R6 lock2 kept");
        do_verify(8'h6B, 16'h0000, "R6 lock addr 0 miss");

        // R7
        do_write(8'h6C, 16'h007F, 8'h5F);
        do_verify(8'h6C, 16'h007F, "R7 enc last");
        do_write(8'h6C, 16'h0080, 8'h00);
        do_verify(8'h6C, 16'h0080, "R7 enc past end");

        // R9 AND only
        do_write(8'h68, 16'h0010, 8'h0F);
        do_write(8'h68, 16'h0010, 8'hF0);
        do_verify(8'h68, 16'h0010, "R9 and accumulate");
        do_write(8'h68, 16'h0011, 8'h0F);
        do_write(8'h68, 16'h0011, 8'hFF);
        do_verify(8'h68, 16'h0011, "R9 no set back");

        // R8 strobe held low, data changes afterwards; R10 oe low while programming
        mode_code = 8'h6C; {addr_hi, addr_lo} = 16'h000A; data_in = 8'hF3;
        prog_en = 1; pulse_n = 0;
        @(posedge clk); #1 data_in = 8'h3F;
        @(negedge clk);
        check(data_oe === 1'b0, "R10 oe low programming", data_oe, 0);
        repeat (3) @(posedge clk);
        #1 pulse_n = 1;
        @(posedge clk); #1 prog_en = 0;
        model_write(8'h6C, 16'h000A, 8'hF3);
        do_verify(8'h6C, 16'h000A, "R8 one write per pulse");

        // R8 no write without prog_en; R10 oe low while pulse low
        mode_code = 8'h6C; {addr_hi, addr_lo} = 16'h000B; data_in = 8'h00;
        prog_en = 0; pulse_n = 0;
        @(negedge clk);
        check(data_oe === 1'b0, "R10 oe low pulse low", data_oe, 0);
        @(posedge clk); #1 pulse_n = 1;
        @(posedge clk); #1;
        do_verify(8'h6C, 16'h000B, "R8 no write without enable");

        // R12
        do_verify(8'h60, 16'h0000, "R12 sig0");
        do_verify(8'h60, 16'h0001, "R12 sig1");
        do_write(8'h60, 16'h0002, 8'h00);
        do_verify(8'h60, 16'h0002, "R12 sig2 unwritten");
        do_verify(8'h55, 16'h0000, "R11 unknown mode");

        // random mix
        for (int i = 0; i < 400; i++) begin
            case ($urandom % 6)
                0: begin m = 8'h68; a = 16'($urandom % (CODE_N + 4)); end
                1: begin m = 8'h69; a = 16'hFFF7 + 16'($urandom % 4); end
                2: begin m = 8'h6B; a = 16'($urandom % 5); end
                3: begin m = 8'h6C; a = 16'($urandom % 132); end
                4: begin m = 8'h60; a = 16'($urandom % 4); end
                default: begin m = 8'($urandom); a = 16'($urandom); end
            endcase
            if ($urandom % 2) do_write(m, a, 8'($urandom) | 8'($urandom));
            else do_verify(m, a, "R4 R11 random read");
        end

        // R3 strobe rise closes
        close_sess();
        mode_code = 8'h68; {addr_hi, addr_lo} = 0; strobe_n = 0;
        @(negedge clk);
        check(data_oe === 1'b0, "R3 closed by strobe", data_oe, 0);
        @(posedge clk); #1;
        close_sess();

        // R3 hold drop closes, restoring hold does not reopen
        open_sess(3);
        do_verify(8'h68, 16'h0010, "R3 reopened");
        dev_hold = 0;
        @(negedge clk);
        check(data_oe === 1'b0, "R3 oe drops with hold", data_oe, 0);
        @(posedge clk); #1 dev_hold = 1;
        @(negedge clk);
        check(data_oe === 1'b0, "R3 no reopen", data_oe, 0);
        @(posedge clk); #1;
        close_sess();

        finish_up();
    end
endmodule